// File: doc/BRIEF.md
# Elastic Word Chain Store

The block is a deep queue for 6-bit words, built as a chain of stages that each hold a word and a valid bit. A word enters through a one-word input register. It then drops in a single step into the empty stage just behind the youngest stored word, so a lightly loaded chain has a short latency whatever its depth. Removing the word at the head does not close the gap at once. The vacancy climbs one stage per clock toward the input end, and each stored word behind it steps forward one place as it passes.

The downstream consumer sees a head word with a valid flag and pulses a take strobe to consume it. The upstream producer sees a ready flag. Ready reports whether the input end can take a word. It does not report whether the chain as a whole is full, so ready can stay low for a while after a removal from a full chain. If ready stays low for more than DEPTH cycles with no removal, the chain really is full. Each stage is a synchronous flip-flop stage that takes the place of a transparent latch, and the timing seen at the ports is the same.

Top module: `elastic_word_chain`

## Requirements
- R1: While rst_n is low at a rising edge, the chain empties. From the next cycle, head_valid is 0 and ready is 1.
- R2: A word is accepted at a rising edge where wr_en and ready are both 1. Accepted words leave the head in the order they were written.
- R3: A write attempted while ready is 0 is dropped. It never appears at the head, and the number of stored words does not change.
- R4: While head_valid is 0, head_data is 0.
- R5: take at an edge with head_valid 1 removes the head word. take while head_valid is 0 has no effect.
- R6: The chain is full (DEPTH words) with no word pending, and the head is taken at edge T. Ready stays 0 after edges T through T+DEPTH-2 and rises after edge T+DEPTH-1. The earliest accepted write is therefore at edge T+DEPTH.
- R7: The chain holds exactly DEPTH words. DEPTH back-to-back writes into an empty chain all see ready 1. With DEPTH words stored and no take, ready stays 0.
- R8: With an empty chain, a word written at edge W is not yet at the head after edge W. It is at the head, with head_valid 1, after edge W+1.
- R9: While take is 0, a valid head word stays valid and unchanged.
- R10: A take and an accepted write at the same edge both take effect. The head word is removed and the new word joins the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WORD_W | Word to store |
| ready | output | 1 | Input end can accept a word this cycle |
| take | input | 1 | Remove the head word |
| head_valid | output | 1 | Head stage holds a word |
| head_data | output | WORD_W | Oldest stored word, 0 when empty |

## Verification
Removal at the head and arrival at the tail can fall in the same cycle. The shift of a stored word into a fresh vacancy can also meet the drop-in of the pending input word. The bench forces the first case by asserting take and wr_en at the same edge on a partly filled chain. It forces the second by writing the first free slot on the exact edge at which ready recovers, after a take from a full chain. It judges both by draining the chain and comparing every word, and the word count, against an order-preserving queue that the bench keeps itself.

// File: rtl/ewc_pkg.sv
// Package: shared types for the elastic word chain.
// Assumes: nothing beyond IEEE 1800-2017.
package ewc_pkg;

    // What a single stage does at the coming clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,   // keep current content
        ACT_PLACE = 2'd1,   // take the pending input word
        ACT_SHIFT = 2'd2,   // take the word from the stage behind
        ACT_LEAVE = 2'd3    // hand the word forward / out, become empty
    } stage_act_e;

endpackage

// File: rtl/ewc_intake.sv
// Module: ewc_intake
// Holds one pending input word for a single cycle and raises ready when
// the chain is sure to have room for it at the next edge.
// Assumes: the locator always finds a slot for a pending word whenever the
// tail stage is empty, so the pending register drains every cycle.
module ewc_intake #(
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              tail_vld,
    input  logic              near_tail_vld,
    output logic              ready,
    output logic              pend_vld,
    output logic [WORD_W-1:0] pend_data
);

    logic accept;

    // Ready: tail free, and the pending word will not occupy the tail.
    always_comb begin
        ready  = !tail_vld && !(pend_vld && near_tail_vld);
        accept = wr_en && ready;
    end

    // Pending register: load on an accepted write, otherwise empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_data <= '0;
        end else begin
            pend_vld <= accept;
            if (accept) begin
                pend_data <= wr_data;
            end
        end
    end

endmodule

// File: rtl/ewc_fill_locator.sv
// Module: ewc_fill_locator
// Finds the stage just behind the youngest stored word: the lowest stage
// with every stage from it up to the tail empty. Output is one-hot or zero.
// Assumes: occupancy already reflects a head removal in this cycle.
module ewc_fill_locator #(
    parameter int DEPTH = 48
) (
    input  logic [DEPTH-1:0] occ,
    input  logic             req,
    output logic [DEPTH-1:0] hit
);

    logic [DEPTH:0] clear_up;

    assign clear_up[DEPTH] = 1'b1;

    for (genvar k = DEPTH - 1; k >= 0; k--) begin : g_scan
        // Suffix chain: stage k and everything above it is empty.
        assign clear_up[k] = clear_up[k+1] && !occ[k];
        if (k == 0) begin : g_head
            assign hit[k] = req && clear_up[k];
        end else begin : g_body
            assign hit[k] = req && clear_up[k] && occ[k-1];
        end
    end

endmodule

// File: rtl/ewc_stage.sv
// Module: ewc_stage
// One storage stage: a word plus a valid bit. An empty stage pulls the
// word from behind; a full stage leaves when the stage ahead is free.
// Assumes: place_hit only when this stage and all stages behind are empty.
module ewc_stage
    import ewc_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lower_free,
    input  logic              upper_vld,
    input  logic [WORD_W-1:0] upper_data,
    input  logic              place_hit,
    input  logic [WORD_W-1:0] place_data,
    output logic              vld,
    output logic [WORD_W-1:0] data
);

    stage_act_e act;

    // Action select: placement first, then pull-forward, then hand-off.
    always_comb begin
        act = ACT_HOLD;
        if (place_hit) begin
            act = ACT_PLACE;
        end else if (!vld && upper_vld) begin
            act = ACT_SHIFT;
        end else if (vld && lower_free) begin
            act = ACT_LEAVE;
        end
    end

    // Stage register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld  <= 1'b0;
            data <= '0;
        end else begin
            case (act)
                ACT_PLACE: begin
                    vld  <= 1'b1;
                    data <= place_data;
                end
                ACT_SHIFT: begin
                    vld  <= 1'b1;
                    data <= upper_data;
                end
                ACT_LEAVE: vld <= 1'b0;
                default:   ;
            endcase
        end
    end

    AST_VACANCY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && lower_free && !place_hit) |=> !vld); // R6

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !lower_free) |=> (vld && $stable(data))); // R9

endmodule

// File: rtl/elastic_word_chain.sv
// Module: elastic_word_chain (top)
// Deep queue of words: an input register, a locator that drops the pending
// word behind the youngest stored word, and a chain of stages in which a
// vacancy at the head climbs one stage per clock.
// Assumes: DEPTH >= 3; take is ignored when the head is empty.
module elastic_word_chain #(
    parameter int WORD_W = 6,
    parameter int DEPTH  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              ready,
    input  logic              take,
    output logic              head_valid,
    output logic [WORD_W-1:0] head_data
);

    localparam int TAIL = DEPTH - 1;

    logic [DEPTH-1:0]  vld;
    logic [WORD_W-1:0] data [DEPTH];
    logic [DEPTH-1:0]  occ_eff;
    logic [DEPTH-1:0]  hit;
    logic              pend_vld;
    logic [WORD_W-1:0] pend_data;
    logic              take_eff;

    // Head removal and occupancy as seen by the locator.
    always_comb begin
        take_eff = take && vld[0];
        occ_eff  = vld;
        occ_eff[0] = vld[0] && !take;
    end

    ewc_intake #(.WORD_W(WORD_W)) u_intake (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .tail_vld      (vld[TAIL]),
        .near_tail_vld (vld[TAIL-1]),
        .ready         (ready),
        .pend_vld      (pend_vld),
        .pend_data     (pend_data)
    );

    ewc_fill_locator #(.DEPTH(DEPTH)) u_locator (
        .occ (occ_eff),
        .req (pend_vld),
        .hit (hit)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic              lower_free_i;
        logic              upper_vld_i;
        logic [WORD_W-1:0] upper_data_i;

        if (i == 0) begin : g_head
            assign lower_free_i = take_eff;
        end else begin : g_inner
            assign lower_free_i = !vld[i-1];
        end

        if (i == TAIL) begin : g_tail
            assign upper_vld_i  = 1'b0;
            assign upper_data_i = '0;
        end else begin : g_link
            assign upper_vld_i  = vld[i+1];
            assign upper_data_i = data[i+1];
        end

        ewc_stage #(.WORD_W(WORD_W)) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .lower_free (lower_free_i),
            .upper_vld  (upper_vld_i),
            .upper_data (upper_data_i),
            .place_hit  (hit[i]),
            .place_data (pend_data),
            .vld        (vld[i]),
            .data       (data[i])
        );
    end

    // Head view, forced to zero when empty.
    always_comb begin
        head_valid = vld[0];
        head_data  = vld[0] ? data[0] : '0;
    end

    AST_PENDING_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld |-> (|hit)); // R2

    AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (&vld) |-> !ready); // R7

    AST_HEAD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !take) |=> (head_valid && $stable(head_data))); // R9

endmodule

// File: tb/test_elastic_word_chain.sv
module test_elastic_word_chain;

    localparam int CLK_PERIOD = 10;
    localparam int W = 6;
    localparam int D = 48;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         take = 1'b0;
    logic         ready;
    logic         head_valid;
    logic [W-1:0] head_data;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [W-1:0] exp_q [$];

    elastic_word_chain #(.WORD_W(W), .DEPTH(D)) i_elastic_word_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ready      (ready),
        .take       (take),
        .head_valid (head_valid),
        .head_data  (head_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic fill(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(ready == 1'b1, "R7 ready during fill", int'(ready), 1);
            wr_en   = 1'b1;
            wr_data = W'((seed * 7 + i * 5 + 1) & 63);
            exp_q.push_back(wr_data);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input int cnt);
        int got = 0;
        int guard = 0;
        while (got < cnt && guard < 400) begin
            @(negedge clk);
            guard++;
            if (head_valid) begin
                check(head_data == exp_q[0], "R2 order", int'(head_data), int'(exp_q[0]));
                void'(exp_q.pop_front());
                got++;
                take = 1'b1;
            end else begin
                check(head_data == '0, "R4 empty head zero", int'(head_data), 0);
                take = 1'b0;
            end
        end
        @(negedge clk);
        take = 1'b0;
        check(got == cnt, "R5 drained count", got, cnt);
        settle(3);
        check(head_valid == 1'b0, "R3 no extra word", int'(head_valid), 0);
        check(ready == 1'b1, "R7 ready when empty", int'(ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=expired exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        settle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
        check(head_valid == 1'b0, "R1 empty after reset", int'(head_valid), 0);
        check(head_data == '0, "R4 head zero after reset", int'(head_data), 0);

        // R5: take on empty chain does nothing
        take = 1'b1;
        settle(2);
        take = 1'b0;
        @(negedge clk);
        check(head_valid == 1'b0, "R5 take on empty", int'(head_valid), 0);

        // R8: latency into an empty chain
        wr_en = 1'b1;
        wr_data = 6'h2D;
        exp_q.push_back(6'h2D);
        @(negedge clk);
        wr_en = 1'b0;
        check(head_valid == 1'b0, "R8 not yet at head", int'(head_valid), 0);
        @(negedge clk);
        check(head_valid == 1'b1, "R8 at head after two edges", int'(head_valid), 1);
        check(head_data == 6'h2D, "R8 head word", int'(head_data), 'h2D);
        drain(1);

        // Sweep every fill level
        for (int n = 1; n <= D; n++) begin
            fill(n, n);
            settle(3);
            if (n < D) begin
                check(ready == 1'b1, "R7 ready below capacity", int'(ready), 1);
            end else begin
                for (int c = 0; c < 60; c++) begin
                    check(ready == 1'b0, "R7 ready low when full", int'(ready), 0);
                    wr_en = 1'b1;
                    wr_data = 6'h3F;
                    @(negedge clk);
                end
                wr_en = 1'b0;
                settle(2);
            end
            drain(n);
        end

        // R6: recovery time after one take from a full chain
        fill(D, 99);
        settle(3);
        check(head_valid == 1'b1, "R6 full head valid", int'(head_valid), 1);
        check(head_data == exp_q[0], "R6 head word", int'(head_data), int'(exp_q[0]));
        void'(exp_q.pop_front());
        take = 1'b1;
        for (int k = 0; k < D; k++) begin
            @(negedge clk);
            take = 1'b0;
            check(ready == (k == D - 1), "R6 ready recovery", int'(ready), int'(k == D - 1));
        end
        wr_en = 1'b1;
        wr_data = 6'h2A;
        exp_q.push_back(6'h2A);
        @(negedge clk);
        wr_en = 1'b0;
        settle(3);
        drain(D);

        // R10: take and write at the same edge
        fill(5, 3);
        settle(3);
        check(head_data == exp_q[0], "R10 head before", int'(head_data), int'(exp_q[0]));
        check(ready == 1'b1, "R10 ready", int'(ready), 1);
        void'(exp_q.pop_front());
        take = 1'b1;
        wr_en = 1'b1;
        wr_data = 6'h15;
        exp_q.push_back(6'h15);
        @(negedge clk);
        take = 1'b0;
        wr_en = 1'b0;
        settle(3);
        drain(5);

        // R9: head holds without take
        fill(3, 11);
        settle(3);
        held = head_data;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check(head_valid == 1'b1 && head_data == held, "R9 head stable",
                  int'(head_data), int'(held));
        end
        drain(3);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule